// File: doc/BRIEF.md
# Byte-Wide Parallel EEPROM Device Core

This block is a clock-sampled, synthesizable model of the control logic inside a 2K x 8 byte-wide EEPROM. It watches three active-low strobes: chip enable, output enable and write enable. Each clock it decides whether the device is being read, is taking a byte write, or is idle. Reads come from an internal array one cycle after the request. A write is taken when the chip-enable and write-enable low periods overlap, with output enable high. Once started, the write completes on an internal timer. While that timer runs, reading the target byte gives a busy pattern in bit 7.

Two digital flags stand in for high-voltage pin conditions. One turns a long write-enable pulse into a whole-array clear. The other maps the top 32 addresses onto a separate identification store. A supply-good flag, together with a power-up delay counter, locks out writes. The write time, power-up delay and minimum clear pulse are parameters counted in clock cycles. The output is modelled as a data bus plus a drive-enable bit, in place of tri-state pins.

Top module: `eeprom_core`

## Requirements
- R1: With ce_n low, oe_n low and we_n high, dout_en is 1 and dout shows the byte at the addressed location on the cycle after the request. Every byte reads 0xFF before it has first been written.
- R2: When ce_n or oe_n is high on a clock edge, dout_en is 0 and dout is 0 after that edge.
- R3: A write cycle is the span during which ce_n and we_n are both low, oe_n is high and oe_hv is low. The byte is committed only if such a span occurs. When oe_n is low during the strobes, nothing is written.
- R4: The address (and a9_hv) is taken from the first clock of the overlap of ce_n and we_n being low. The data is taken from the last clock of that overlap.
- R5: After a write cycle ends, the write runs for WRITE_CYC clocks. The target is first erased to all ones, and the new byte is stored at the end of that time.
- R6: During a running write, a read of the target location returns the complement of the new byte's bit 7 on dout[7]. The other bits are undefined. After completion, the true byte is returned.
- R7: Writes and clears are ignored while supply_ok is low, and for PWRUP_CYC clocks after supply_ok rises.
- R8: A write cycle that ends while a write or clear is running is ignored.
- R9: A strobe with ce_n low, oe_hv high and we_n low for at least CLEAR_CYC clocks clears the array when we_n or ce_n rises. Every main-array byte is then set to 0xFF over the following 2^ADDR_W clocks. A shorter pulse has no effect, and the identification store is not touched.
- R10: When a9_hv is 1 and addr[10:5] are all ones (0x7E0 to 0x7FF), reads and writes use a separate 32-byte identification store indexed by addr[4:0]. The main-array byte at the same address is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_hv | input | 1 | Output-enable high-voltage flag (selects chip clear) |
| a9_hv | input | 1 | Address-bit-9 high-voltage flag (selects identification store) |
| supply_ok | input | 1 | Supply above write threshold |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
Writes are driven in four shapes: a single-clock overlap, a multi-clock overlap with the address and data changing part way through, staggered strobes where chip enable falls first and rises first, and a strobe with output enable low. Between them these show whether the address is captured at the start of the overlap and the data at its end, and whether output enable gates the write. Reads are issued right after a write and again after the timer expires, which separates the poll pattern from true data. Clear pulses of lengths just below and above the limit, plus accesses with the identification flag on and off, show that the clear threshold holds and that the two stores stay apart.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_CLEAR = 2'd2
  } seq_state_t;
endpackage

// File: rtl/eeprom_strobe.sv
// Strobe decoder: finds write spans and clear pulses, latches address on
// the first cycle of overlap and data on every cycle until it ends.
module eeprom_strobe #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CLEAR_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_a9,
  output logic [DATA_W-1:0] wr_data,
  output logic              clr_req
);
  localparam int CLR_W = $clog2(CLEAR_CYC + 1);

  logic             wp, wp_q, cp, cp_q;
  logic [CLR_W-1:0] cp_cnt;

  assign wp = !ce_n && !we_n && oe_n && !oe_hv;
  assign cp = !ce_n && !we_n && oe_hv;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= 1'b0;
      cp_q    <= 1'b0;
      cp_cnt  <= '0;
      wr_addr <= '0;
      wr_a9   <= 1'b0;
      wr_data <= '0;
    end else begin
      wp_q <= wp;
      cp_q <= cp;
      if (wp && !wp_q) begin
        wr_addr <= addr;
        wr_a9   <= a9_hv;
      end
      if (wp) wr_data <= din;
      if (!cp) cp_cnt <= '0;
      else if (cp_cnt != CLR_W'(CLEAR_CYC)) cp_cnt <= cp_cnt + 1'b1;
    end
  end

  assign wr_req  = wp_q && !wp;
  assign clr_req = cp_q && !cp && (cp_cnt == CLR_W'(CLEAR_CYC));

  // R4: address stays put for the rest of the overlap
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wp && wp_q) |=> $stable(wr_addr));
  // R4: data tracks din until the overlap ends
  p_data_last_r4: assert property (@(posedge clk) disable iff (rst)
    wp |=> (wr_data == $past(din)));
endmodule

// File: rtl/eeprom_pwrup.sv
// Power-up write lockout: counts clocks of good supply.
module eeprom_pwrup #(
  parameter int PWRUP_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic wr_ok
);
  localparam int PW_W = $clog2(PWRUP_CYC + 1);

  logic [PW_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) cnt <= '0;
    else if (cnt != PW_W'(PWRUP_CYC)) cnt <= cnt + 1'b1;
  end

  assign wr_ok = supply_ok && (cnt == PW_W'(PWRUP_CYC));

  // R7: unlock only after a full count of good supply
  p_unlock_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_ok) |-> $past(supply_ok));
endmodule

// File: rtl/eeprom_seq.sv
// Self-timed write / clear sequencer driving the single array write port.
module eeprom_seq
  import eeprom_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 2048,
  parameter int WRITE_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              wr_req,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_req,
  output logic              busy_wr,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic              tgt_bit7,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int TW = $clog2(WRITE_CYC + 1);

  seq_state_t        state;
  logic [TW-1:0]     timer;
  logic [IDX_W-1:0]  ptr;
  logic [DATA_W-1:0] tgt_data;
  logic              timer_end;

  assign timer_end = (timer == TW'(WRITE_CYC - 1));

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = tgt_idx;
    mem_wdata = {DATA_W{1'b1}};
    case (state)
      ST_IDLE: if (wr_ok && wr_req) begin
        mem_we    = 1'b1;
        mem_waddr = wr_idx;
      end
      ST_WRITE: if (timer_end) begin
        mem_we    = 1'b1;
        mem_wdata = tgt_data;
      end
      ST_CLEAR: begin
        mem_we    = 1'b1;
        mem_waddr = ptr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      timer    <= '0;
      ptr      <= '0;
      tgt_idx  <= '0;
      tgt_data <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wr_ok && wr_req) begin
            state    <= ST_WRITE;
            timer    <= '0;
            tgt_idx  <= wr_idx;
            tgt_data <= wr_data;
          end else if (wr_ok && clr_req) begin
            state <= ST_CLEAR;
            ptr   <= '0;
          end
        end
        ST_WRITE: begin
          if (timer_end) state <= ST_IDLE;
          else timer <= timer + 1'b1;
        end
        ST_CLEAR: begin
          if (ptr == IDX_W'(DEPTH - 1)) state <= ST_IDLE;
          else ptr <= ptr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_wr  = (state == ST_WRITE);
  assign tgt_bit7 = tgt_data[DATA_W-1];

  // R5: a write begins by erasing its target
  p_erase_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_WRITE) |-> ($past(mem_we) && ($past(mem_wdata) == {DATA_W{1'b1}})
                                  && ($past(mem_waddr) == tgt_idx)));
  // R5: the timer holds the write until it expires
  p_timer_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE && !timer_end) |=> (state == ST_WRITE));
  // R7: nothing starts while locked out
  p_lockout_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !wr_ok) |=> (state == ST_IDLE));
  // R8: a new strobe during a write leaves the pending byte alone
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE && wr_req) |=> $stable(tgt_data));
  // R9: clearing only writes ones into the main array
  p_clear_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLEAR) |-> (mem_we && (mem_wdata == {DATA_W{1'b1}})
                             && (mem_waddr < IDX_W'(DEPTH))));
endmodule

// File: rtl/eeprom_ram.sv
// Simple dual-port array, one write and one registered read, erased at start.
module eeprom_ram #(
  parameter int IDX_W  = 12,
  parameter int DATA_W = 8,
  parameter int WORDS  = 2080
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = {DATA_W{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_core.sv
module eeprom_core #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ID_BYTES  = 32,
  parameter int WRITE_CYC = 10000,
  parameter int PWRUP_CYC = 250000,
  parameter int CLEAR_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic              supply_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ID_W  = $clog2(ID_BYTES);
  localparam int WORDS = DEPTH + ID_BYTES;
  localparam int IDX_W = $clog2(WORDS);

  function automatic logic [IDX_W-1:0] map_idx(input logic [ADDR_W-1:0] a, input logic hv);
    if (hv && (&a[ADDR_W-1:ID_W])) return IDX_W'(DEPTH) + IDX_W'(a[ID_W-1:0]);
    else return IDX_W'(a);
  endfunction

  logic              wr_req, wr_a9, clr_req, wr_ok, busy_wr, tgt_bit7;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, mem_wdata, rd_q;
  logic [IDX_W-1:0]  tgt_idx, mem_waddr, rd_idx;
  logic              mem_we, poll_hit, poll_b7;

  eeprom_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_CYC(CLEAR_CYC)) u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .oe_hv(oe_hv),
    .a9_hv(a9_hv), .addr(addr), .din(din), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_a9(wr_a9), .wr_data(wr_data), .clr_req(clr_req));

  eeprom_pwrup #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wr_ok(wr_ok));

  eeprom_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_req(wr_req),
    .wr_idx(map_idx(wr_addr, wr_a9)), .wr_data(wr_data), .clr_req(clr_req),
    .busy_wr(busy_wr), .tgt_idx(tgt_idx), .tgt_bit7(tgt_bit7),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  assign rd_idx = map_idx(addr, a9_hv);

  eeprom_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_idx), .rdata(rd_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en  <= 1'b0;
      poll_hit <= 1'b0;
      poll_b7  <= 1'b0;
    end else begin
      dout_en  <= !ce_n && !oe_n && we_n;
      poll_hit <= busy_wr && (rd_idx == tgt_idx);
      poll_b7  <= !tgt_bit7;
    end
  end

  always_comb begin
    if (!dout_en)     dout = '0;
    else if (poll_hit) dout = {poll_b7, {(DATA_W-1){1'b0}}};
    else              dout = rd_q;
  end

  // R2: a high ce_n or oe_n releases the bus on the next cycle
  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> (!dout_en && dout == '0));
  // R1: a read request drives the bus on the next cycle
  p_drive_r1: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> dout_en);
endmodule

// File: tb/test_eeprom_core.sv
module test_eeprom_core;
  localparam int WCYC = 8;
  localparam int PCYC = 20;
  localparam int CCYC = 10;
  localparam int DEP  = 2048;

  logic       clk = 1'b0;
  logic       rst, ce_n, oe_n, we_n, oe_hv, a9_hv, supply_ok;
  logic [10:0] addr;
  logic [7:0]  din, dout;
  logic        dout_en;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] mask_q[$];
  logic       en_q[$];
  int         due_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_core #(.WRITE_CYC(WCYC), .PWRUP_CYC(PCYC), .CLEAR_CYC(CCYC)) i_eeprom_core (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .oe_hv(oe_hv),
    .a9_hv(a9_hv), .supply_ok(supply_ok), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en));

  // monitor: compare the oldest expected item when its cycle comes
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [7:0] e, m;
      logic       en;
      string      t;
      e = exp_q.pop_front(); m = mask_q.pop_front(); en = en_q.pop_front();
      t = tag_q.pop_front(); void'(due_q.pop_front());
      total++;
      if (dout_en !== en || (dout & m) !== (e & m)) begin
        bad++;
        $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h (mask %02h)",
                 t, dout_en, dout, en, e, m);
      end
    end
  end

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic en, logic [7:0] e, logic [7:0] m, string t);
    en_q.push_back(en); exp_q.push_back(e); mask_q.push_back(m);
    tag_q.push_back(t); due_q.push_back(cyc + 1);
  endtask

  task automatic rd(logic [10:0] a, logic hv, logic [7:0] e, logic [7:0] m, string t);
    addr = a; a9_hv = hv; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    push(1'b1, e, m, t);
    wait_cyc(1);
    idle();
  endtask

  task automatic wr(logic [10:0] a, logic hv, logic [7:0] d);
    addr = a; a9_hv = hv; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    wait_cyc(1);
    idle();
    wait_cyc(1);
  endtask

  task automatic clr_pulse(int n);
    ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; we_n = 1'b0; a9_hv = 1'b0;
    wait_cyc(n);
    idle();
    wait_cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; supply_ok = 1'b0; addr = '0; din = '0; a9_hv = 1'b0;
    idle();
    wait_cyc(3);
    rst = 1'b0;
    // reset state: bus released (R2)
    push(1'b0, 8'h00, 8'hFF, "R2 reset release");
    wait_cyc(1);
    rd(11'h005, 1'b0, 8'hFF, 8'hFF, "R1 erased at start");
    // R7: supply low
    wr(11'h005, 1'b0, 8'h12);
    wait_cyc(WCYC + 3);
    rd(11'h005, 1'b0, 8'hFF, 8'hFF, "R7 write with supply low");
    // R7: inside power-up delay
    supply_ok = 1'b1;
    wait_cyc(4);
    wr(11'h005, 1'b0, 8'h34);
    wait_cyc(WCYC + 3);
    rd(11'h005, 1'b0, 8'hFF, 8'hFF, "R7 write in power-up delay");
    wait_cyc(PCYC + 5);
    // R3/R5/R6: basic write, poll, then true data
    wr(11'h010, 1'b0, 8'h5A);
    rd(11'h010, 1'b0, 8'h80, 8'h80, "R6 poll bit7 of 5A");
    wait_cyc(WCYC + 2);
    rd(11'h010, 1'b0, 8'h5A, 8'hFF, "R5 data after timer");
    wr(11'h011, 1'b0, 8'hC3);
    rd(11'h011, 1'b0, 8'h00, 8'h80, "R6 poll bit7 of C3");
    wait_cyc(WCYC + 2);
    rd(11'h011, 1'b0, 8'hC3, 8'hFF, "R3 simple write");
    // R4: address from first overlap cycle, data from last
    addr = 11'h020; din = 8'h11; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    wait_cyc(1);
    addr = 11'h021; din = 8'h22;
    wait_cyc(1);
    din = 8'h77;
    wait_cyc(1);
    idle();
    wait_cyc(WCYC + 3);
    rd(11'h020, 1'b0, 8'h77, 8'hFF, "R4 long pulse first addr last data");
    rd(11'h021, 1'b0, 8'hFF, 8'hFF, "R4 later addr untouched");
    // R4: staggered strobes, ce_n falls first and rises first
    addr = 11'h030; din = 8'h00; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    wait_cyc(1);
    addr = 11'h031; din = 8'h44; we_n = 1'b0;
    wait_cyc(1);
    ce_n = 1'b1; din = 8'h99;
    wait_cyc(1);
    idle();
    wait_cyc(WCYC + 3);
    rd(11'h031, 1'b0, 8'h44, 8'hFF, "R4 staggered strobes");
    rd(11'h030, 1'b0, 8'hFF, 8'hFF, "R4 staggered early addr untouched");
    // R3: oe_n low blocks the write
    addr = 11'h040; din = 8'h01; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    wait_cyc(1);
    idle();
    wait_cyc(WCYC + 3);
    rd(11'h040, 1'b0, 8'hFF, 8'hFF, "R3 oe_n low inhibits");
    // R8: second write during busy is dropped
    wr(11'h050, 1'b0, 8'h55);
    wr(11'h051, 1'b0, 8'h66);
    wait_cyc(WCYC + 3);
    rd(11'h051, 1'b0, 8'hFF, 8'hFF, "R8 write during busy ignored");
    rd(11'h050, 1'b0, 8'h55, 8'hFF, "R8 first write kept");
    // R10: identification store
    wr(11'h7E3, 1'b1, 8'hA5);
    wait_cyc(WCYC + 3);
    rd(11'h7E3, 1'b1, 8'hA5, 8'hFF, "R10 id store read");
    rd(11'h7E3, 1'b0, 8'hFF, 8'hFF, "R10 main byte unaffected");
    wr(11'h7E3, 1'b0, 8'h3C);
    wait_cyc(WCYC + 3);
    rd(11'h7E3, 1'b0, 8'h3C, 8'hFF, "R10 main byte written");
    rd(11'h7E3, 1'b1, 8'hA5, 8'hFF, "R10 id unaffected by main write");
    // R2: oe_n high with ce_n low
    addr = 11'h010; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    push(1'b0, 8'h00, 8'hFF, "R2 oe_n high releases");
    wait_cyc(1);
    idle();
    // R9: short clear pulse does nothing
    clr_pulse(CCYC - 5);
    wait_cyc(DEP + 5);
    rd(11'h010, 1'b0, 8'h5A, 8'hFF, "R9 short clear pulse no effect");
    // R9: long pulse clears main array only
    clr_pulse(CCYC + 2);
    wait_cyc(DEP + 5);
    rd(11'h010, 1'b0, 8'hFF, 8'hFF, "R9 cleared low byte");
    rd(11'h7E3, 1'b0, 8'hFF, 8'hFF, "R9 cleared top byte");
    rd(11'h050, 1'b0, 8'hFF, 8'hFF, "R9 cleared mid byte");
    rd(11'h7E3, 1'b1, 8'hA5, 8'hFF, "R9 id store kept");
    wait_cyc(3);
    if (due_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", due_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule